// File: doc/BRIEF.md
# Mixed-Class Output Link Arbiter

This block decides, on every byte cycle, what one outgoing mesh link carries. The link is shared by two virtual channels. One carries fixed-size time-constrained packets that have already been ranked by a deadline scheduler. The other carries variable-length best-effort worms that cut through from several input links. The scheduler presents one candidate packet together with a flag that says whether the packet is on-time or early. Each best-effort input presents its flits one at a time, and a per-link acknowledge line returns downstream buffer space.

Priority has three levels. An on-time packet comes first and may cut into a worm between two flits. Best-effort flits come next. An early packet comes last, and it may use the link only when its logical arrival time lies within the programmed horizon of the current time. A best-effort input that wins the link keeps it until the whole worm has gone out, including across preemptions. A round-robin pointer picks the next input. The arbiter tracks each worm through its three-flit header. The length in that header fixes how many body flits follow.

Top module: `vc_link_arbiter`

## Requirements
- R1: After reset the link is idle (link_valid low, no be_pop), the credit count equals CREDITS, and the round-robin search starts at input 0.
- R2: link_class is 1 on every cycle that carries a time-constrained byte, taken from tc_data. It is 0 on every cycle that carries a best-effort flit, taken from the owning input's be_data slice.
- R3: An on-time packet (tc_valid=1, tc_early=0) takes the link between any two flits of a worm. Once the packet ends, the same worm resumes with its next flit, and no other input sends in between.
- R4: A time-constrained packet, once started, occupies the link for exactly TC_BYTES consecutive cycles, with tc_take high on each one. No other class interrupts it. tc_done is high only in the cycle that carries its last byte.
- R5: When an early packet is within the horizon and a best-effort flit can be sent, the flit goes first.
- R6: An early packet is started only when no on-time packet is offered, no best-effort flit can be sent, and (tc_arrival - now) modulo 2^TIME_W is at most horizon. Otherwise the link stays idle.
- R7: When no worm owns the link, the winner is the first input with be_valid high, searching upward from the input after the last completed worm and wrapping past N_IN-1. The pointer moves only when a worm completes.
- R8: A worm is three header flits in order: x offset, y offset, then length L in the third flit. L body flits follow. Ownership ends with flit 3+L.
- R9: A best-effort flit is sent only while the credit count is nonzero. Each flit spends one credit. link_ack high in a cycle adds one credit from the next cycle, and the count never exceeds CREDITS.
- R10: While the credit count is zero, the best-effort channel counts as empty, so an early packet inside the horizon may start.
- R11: be_pop is one-hot or zero, and it marks exactly the input whose flit is on the link in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| now | input | TIME_W | Current link time |
| horizon | input | TIME_W | Early-send window for this link |
| tc_valid | input | 1 | Scheduler offers a packet |
| tc_early | input | 1 | 1 = offered packet is early, 0 = on-time |
| tc_arrival | input | TIME_W | Logical arrival time of the offered packet |
| tc_data | input | DATA_W | Current byte of the time-constrained packet |
| tc_take | output | 1 | A time-constrained byte is on the link this cycle |
| tc_done | output | 1 | Last byte of the packet is on the link this cycle |
| be_valid | input | N_IN | Per-input best-effort flit available |
| be_data | input | N_IN*DATA_W | Per-input flit, input i in bits [i*DATA_W +: DATA_W] |
| be_pop | output | N_IN | Flit of that input consumed this cycle |
| link_ack | input | 1 | Downstream returns one best-effort buffer slot |
| link_valid | output | 1 | A byte is on the link |
| link_class | output | 1 | 1 = time-constrained, 0 = best-effort |
| link_data | output | DATA_W | Byte on the link |

## Verification
The worm tracker is the block's most fragile state. A wrong phase or body count does not corrupt data on its own; it releases or keeps ownership at the wrong flit. That shows up on the very next flit as a be_pop from the wrong input, or as a flit that the round-robin order does not predict. A credit count that has drifted shows up when acknowledges stop: the link sends one flit too many or stalls one flit early. A wrong time-constrained byte counter shows up as tc_done landing off the twentieth byte, or as a best-effort flit appearing inside a packet. The sweep over arrival offsets and horizons, including a clock that wraps, exposes a wrong window comparison within one cycle of the offer.

// File: rtl/vcla_pkg.sv
package vcla_pkg;

    // Worm header layout: the third flit carries the body length.
    typedef enum logic [1:0] {
        W_XOFF = 2'd0,
        W_YOFF = 2'd1,
        W_LEN  = 2'd2,
        W_BODY = 2'd3
    } worm_ph_e;

    typedef enum logic [1:0] {
        PICK_IDLE = 2'd0,
        PICK_TC   = 2'd1,
        PICK_BE   = 2'd2
    } pick_e;

    typedef struct packed {
        logic tc_busy;   // a deadline packet is mid-flight
        logic ontime;    // on-time packet offered
        logic be_ready;  // a best-effort flit can be sent
        logic early_ok;  // early packet inside the horizon
    } link_req_s;

    function automatic pick_e choose_class(link_req_s r);
        if (r.tc_busy || r.ontime) return PICK_TC;
        if (r.be_ready)            return PICK_BE;
        if (r.early_ok)            return PICK_TC;
        return PICK_IDLE;
    endfunction

endpackage

// File: rtl/vcla_rr_pick.sv
module vcla_rr_pick #(
    parameter int N_IN  = 3,
    parameter int IDX_W = 2
) (
    input  logic [N_IN-1:0]  req,
    input  logic [IDX_W-1:0] ptr,
    output logic             any,
    output logic [IDX_W-1:0] gidx
);
    always_comb begin
        any  = 1'b0;
        gidx = '0;
        for (int off = 0; off < N_IN; off++) begin
            int c;
            c = int'(ptr) + off;
            if (c >= N_IN) c = c - N_IN;
            if (!any && req[c]) begin
                any  = 1'b1;
                gidx = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/vcla_credit.sv
module vcla_credit #(
    parameter int CREDITS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    input  logic spend,
    output logic avail
);
    localparam int CW = $clog2(CREDITS + 1);

    logic [CW-1:0] cred;

    always_ff @(posedge clk) begin
        if (rst) begin
            cred <= CW'(CREDITS);
        end else begin
            case ({ack, spend})
                2'b10:   if (cred != CW'(CREDITS)) cred <= cred + 1'b1;
                2'b01:   cred <= cred - 1'b1;
                default: cred <= cred;
            endcase
        end
    end

    assign avail = (cred != '0);

    // R9
    credit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cred <= CW'(CREDITS));

    // R9
    no_credit_send_chk: assert property (@(posedge clk) disable iff (rst)
        spend |-> avail);
endmodule

// File: rtl/vcla_worm_track.sv
module vcla_worm_track
    import vcla_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              send,
    input  logic [IDX_W-1:0]  new_idx,
    input  logic [DATA_W-1:0] flit,
    output logic              owned,
    output logic [IDX_W-1:0]  owner,
    output logic [IDX_W-1:0]  rr_ptr,
    output logic              last
);
    worm_ph_e          ph;
    logic [DATA_W-1:0] left;

    always_comb begin
        last = owned && (((ph == W_LEN) && (flit == '0)) ||
                         ((ph == W_BODY) && (left == DATA_W'(1))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owned  <= 1'b0;
            owner  <= '0;
            rr_ptr <= '0;
            ph     <= W_XOFF;
            left   <= '0;
        end else if (send) begin
            if (!owned) begin
                owned <= 1'b1;
                owner <= new_idx;
                ph    <= W_YOFF;
            end else if (last) begin
                owned  <= 1'b0;
                ph     <= W_XOFF;
                rr_ptr <= (owner == IDX_W'(N_IN - 1)) ? '0 : owner + 1'b1;
            end else begin
                case (ph)
                    W_XOFF: ph <= W_YOFF;
                    W_YOFF: ph <= W_LEN;
                    W_LEN: begin
                        left <= flit;
                        ph   <= W_BODY;
                    end
                    default: left <= left - 1'b1;
                endcase
            end
        end
    end

    // R3
    owner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (owned && !(send && last)) |=> (owned && owner == $past(owner)));

    // R8
    body_count_chk: assert property (@(posedge clk) disable iff (rst)
        (owned && ph == W_BODY) |-> (left != '0));
endmodule

// File: rtl/vcla_tc_seq.sv
module vcla_tc_seq #(
    parameter int TC_BYTES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy,
    output logic last
);
    localparam int CNT_W = $clog2(TC_BYTES);

    logic [CNT_W-1:0] cnt;

    assign last = go && (cnt == CNT_W'(TC_BYTES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (go) begin
            if (last) begin
                cnt  <= '0;
                busy <= 1'b0;
            end else begin
                cnt  <= cnt + 1'b1;
                busy <= 1'b1;
            end
        end
    end

    // R4
    busy_go_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> go);

    // R4
    end_release_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> !busy);
endmodule

// File: rtl/vc_link_arbiter.sv
module vc_link_arbiter
    import vcla_pkg::*;
#(
    parameter int N_IN     = 3,
    parameter int DATA_W   = 8,
    parameter int TIME_W   = 8,
    parameter int TC_BYTES = 20,
    parameter int CREDITS  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [TIME_W-1:0]      now,
    input  logic [TIME_W-1:0]      horizon,
    input  logic                   tc_valid,
    input  logic                   tc_early,
    input  logic [TIME_W-1:0]      tc_arrival,
    input  logic [DATA_W-1:0]      tc_data,
    output logic                   tc_take,
    output logic                   tc_done,
    input  logic [N_IN-1:0]        be_valid,
    input  logic [N_IN*DATA_W-1:0] be_data,
    output logic [N_IN-1:0]        be_pop,
    input  logic                   link_ack,
    output logic                   link_valid,
    output logic                   link_class,
    output logic [DATA_W-1:0]      link_data
);
    localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic              owned, worm_last, pick_any, cred_ok, tc_busy;
    logic              owner_valid, be_have, be_send, tc_go;
    logic [IDX_W-1:0]  owner, rr_ptr, pick_idx, be_src;
    logic [DATA_W-1:0] be_byte;
    logic [TIME_W-1:0] ahead;
    link_req_s         req;
    pick_e             sel;

    vcla_rr_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_pick (
        .req (be_valid),
        .ptr (rr_ptr),
        .any (pick_any),
        .gidx(pick_idx)
    );

    vcla_credit #(.CREDITS(CREDITS)) u_credit (
        .clk  (clk),
        .rst  (rst),
        .ack  (link_ack),
        .spend(be_send),
        .avail(cred_ok)
    );

    vcla_worm_track #(.N_IN(N_IN), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_worm (
        .clk    (clk),
        .rst    (rst),
        .send   (be_send),
        .new_idx(pick_idx),
        .flit   (be_byte),
        .owned  (owned),
        .owner  (owner),
        .rr_ptr (rr_ptr),
        .last   (worm_last)
    );

    vcla_tc_seq #(.TC_BYTES(TC_BYTES)) u_tc (
        .clk (clk),
        .rst (rst),
        .go  (tc_go),
        .busy(tc_busy),
        .last(tc_done)
    );

    // Best-effort source selection and availability.
    always_comb begin
        be_src      = owned ? owner : pick_idx;
        owner_valid = 1'b0;
        be_byte     = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (owner == IDX_W'(i)) owner_valid = be_valid[i];
            if (be_src == IDX_W'(i)) be_byte = be_data[i*DATA_W +: DATA_W];
        end
        be_have = owned ? owner_valid : pick_any;
    end

    // Class decision.
    always_comb begin
        ahead        = tc_arrival - now;
        req.tc_busy  = tc_busy;
        req.ontime   = tc_valid && !tc_early;
        req.be_ready = be_have && cred_ok;
        req.early_ok = tc_valid && tc_early && (ahead <= horizon);
        sel          = choose_class(req);
        tc_go        = (sel == PICK_TC);
        be_send      = (sel == PICK_BE);
    end

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            be_pop[i] = be_send && (be_src == IDX_W'(i));
        end
        tc_take    = tc_go;
        link_valid = tc_go || be_send;
        link_class = tc_go;
        link_data  = tc_go ? tc_data : (be_send ? be_byte : '0);
    end

    // R4
    tc_locked_chk: assert property (@(posedge clk) disable iff (rst)
        tc_busy |-> (link_valid && link_class));

    // R11
    pop_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(be_pop) && ((be_pop != '0) == (link_valid && !link_class)));

    // R5
    early_yield_chk: assert property (@(posedge clk) disable iff (rst)
        (!tc_busy && tc_go && tc_early) |-> !(be_have && cred_ok));
endmodule

// File: tb/vc_link_arbiter_test.sv
module vc_link_arbiter_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic           rst;
    logic [7:0]     now, horizon, tc_arrival, tc_data, link_data;
    logic           tc_valid, tc_early, tc_take, tc_done;
    logic [N-1:0]   be_valid, be_pop;
    logic [N*8-1:0] be_data;
    logic           link_ack, link_valid, link_class;
    logic [N-1:0]   be_on;
    int             idx [N];
    int             n_chk = 0;
    int             n_bad = 0;
    bit             finished = 0;

    vc_link_arbiter uut (
        .clk(clk), .rst(rst), .now(now), .horizon(horizon),
        .tc_valid(tc_valid), .tc_early(tc_early), .tc_arrival(tc_arrival),
        .tc_data(tc_data), .tc_take(tc_take), .tc_done(tc_done),
        .be_valid(be_valid), .be_data(be_data), .be_pop(be_pop),
        .link_ack(link_ack), .link_valid(link_valid),
        .link_class(link_class), .link_data(link_data)
    );

    function automatic int wlen(int i);
        return (i == 0) ? 2 : ((i == 1) ? 0 : 1);
    endfunction

    function automatic logic [7:0] flit(int i, int k);
        if (k == 0) return 8'(8'h10 + i);
        if (k == 1) return 8'(8'h20 + i);
        if (k == 2) return 8'(wlen(i));
        return 8'(8'h40 + i * 16 + k);
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) begin
            be_valid[i]       = be_on[i];
            be_data[i*8 +: 8] = flit(i, idx[i]);
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) idx[i] <= 0;
            else if (be_pop[i]) idx[i] <= (idx[i] + 1 == 3 + wlen(i)) ? 0 : idx[i] + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(posedge clk);
        #2;
    endtask

    task automatic expect_be(string tag, int i, int k);
        #1;
        chk({tag, " R2 valid"}, int'(link_valid), 1);
        chk({tag, " R2 class"}, int'(link_class), 0);
        chk({tag, " R2 data"}, int'(link_data), int'(flit(i, k)));
        chk({tag, " R11 pop"}, int'(be_pop), 1 << i);
    endtask

    task automatic expect_idle(string tag);
        #1;
        chk({tag, " idle"}, int'(link_valid), 0);
        chk({tag, " R11 no pop"}, int'(be_pop), 0);
    endtask

    // Caller has advanced to the packet's first cycle and set the offer.
    task automatic run_tc(string tag);
        for (int b = 0; b < 20; b++) begin
            if (b > 0) nxt();
            tc_data = 8'(8'hC0 + b);
            #1;
            chk({tag, " R4 class"}, int'(link_valid && link_class), 1);
            chk({tag, " R2 tc data"}, int'(link_data), 8'hC0 + b);
            chk({tag, " R4 take"}, int'(tc_take), 1);
            chk({tag, " R4 done"}, int'(tc_done), (b == 19) ? 1 : 0);
        end
    endtask

    task automatic worm(string tag, int i);
        for (int k = 0; k < 3 + wlen(i); k++) begin
            nxt();
            expect_be(tag, i, k);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1; now = 0; horizon = 0; tc_arrival = 0; tc_data = 0;
        tc_valid = 0; tc_early = 0; be_on = '0; link_ack = 0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        expect_idle("R1 reset");

        // Credits start full: four flits, then a stall (R1, R9).
        nxt(); be_on = 3'b001; expect_be("R1 first grant", 0, 0);
        for (int k = 1; k < 4; k++) begin nxt(); expect_be("R9 credit", 0, k); end
        nxt(); link_ack = 1; expect_idle("R9 no credit");
        nxt(); link_ack = 0; expect_be("R9 ack credit", 0, 4);
        nxt(); expect_idle("R9 spent");

        // Zero credit: early packet may go (R10).
        nxt(); tc_valid = 1; tc_early = 1; tc_arrival = now; horizon = 0;
        run_tc("R10 early without credit");
        nxt(); tc_valid = 0; be_on = '0; link_ack = 1; expect_idle("R10 after");
        for (int c = 0; c < 4; c++) begin nxt(); expect_idle("R9 refill"); end

        // Round robin over full worms (R7, R8).
        nxt(); be_on = 3'b111; expect_be("R7 order", 1, 0);
        for (int k = 1; k < 3; k++) begin nxt(); expect_be("R8 worm", 1, k); end
        worm("R7 order", 2);
        worm("R7 order", 0);
        worm("R8 repeat", 1);

        // Pointer at 2, input 2 absent: wraps to 0 (R7).
        nxt(); be_on = 3'b011; expect_be("R7 wrap", 0, 0);
        for (int k = 1; k < 5; k++) begin nxt(); expect_be("R8 worm", 0, k); end

        // On-time preemption mid-worm (R3).
        nxt(); be_on = 3'b100; expect_be("R7 skip", 2, 0);
        nxt(); expect_be("R3 pre", 2, 1);
        nxt(); be_on = 3'b111; tc_valid = 1; tc_early = 0;
        run_tc("R3 preempt");
        nxt(); tc_valid = 0; expect_be("R3 resume", 2, 2);
        nxt(); expect_be("R3 resume", 2, 3);
        worm("R7 after resume", 0);

        // Best effort ahead of early (R5), then early fills a gap (R6).
        nxt(); be_on = 3'b010; tc_valid = 1; tc_early = 1; tc_arrival = now; horizon = 3;
        expect_be("R5 be first", 1, 0);
        nxt(); be_on = '0;
        run_tc("R6 early in gap");
        nxt(); tc_valid = 0; be_on = 3'b010; expect_be("R3 resume after early", 1, 1);
        nxt(); expect_be("R8 end", 1, 2);
        nxt(); be_on = '0; expect_idle("R8 released");

        // Horizon window sweep, including clock wrap (R6).
        for (int nb = 0; nb < 2; nb++) begin
            for (int d = 0; d < 6; d++) begin
                for (int hz = 0; hz < 4; hz++) begin
                    nxt();
                    now = (nb == 0) ? 8'd0 : 8'd253;
                    horizon = 8'(hz);
                    tc_arrival = 8'(now + d);
                    tc_valid = 1; tc_early = 1; tc_data = 8'hC0;
                    #1;
                    chk("R6 window", int'(link_valid), (d <= hz) ? 1 : 0);
                    if (d <= hz) run_tc("R6 early");
                    nxt(); tc_valid = 0;
                    expect_idle("R6 after");
                end
            end
        end

        summary();
        $finish;
    end
endmodule